// File: doc/BRIEF.md
# Processor Local Reset Sequencer

This block sequences a reset of one processor core that the surrounding system asks for while the chip-wide reset stays inactive. When a request arrives, the block first asks the pipeline to drain. It waits until the pipeline reports that it is empty, and only then puts the core into its held-reset state. On entry it signals that the reset has been taken with a one-cycle pulse. While the request remains asserted, it repeats that pulse at a fixed interval. It also issues a read of the reset address at each of those instants and throws the returned data away.

While the core is paused by the debugger, the request has no effect. A request that is still asserted at the moment the debugger lets go is acted on, even if the debugger lets go for only one cycle, as it does during a single step. When the request is withdrawn, the core leaves reset and emits a one-cycle restart pulse. If a dummy read is still in flight at that moment, the block waits for its data to come back before it leaves. The global reset is asynchronous and overrides everything.

Top module: `local_reset_seq`

## Requirements
- R1: The active-low global reset `rst_n` acts asynchronously. While it is low, every output is 0 at once, with no clock edge needed, and the block returns to idle.
- R2: In idle, a request that is sampled while `dbg_paused_i`=0 raises `drain_req_o` from the next cycle. `drain_req_o` stays high until an edge at which the request, `pipe_empty_i`=1 and `dbg_paused_i`=0 are all present. From that edge on, `drain_req_o` is 0 and `core_held_o` is 1.
- R3: On entering the held state, `rst_taken_o` is 1 for exactly one cycle. That cycle is the first cycle in which `core_held_o` is 1.
- R4: While the request stays asserted in the held state, `rst_taken_o` pulses again every PERIOD cycles (default 16) after the entry pulse, and is 0 in between.
- R5: A dummy read is a one-cycle `rd_req_o` pulse with `rd_addr_o` equal to RESET_ADDR (default 0x00001000). One is issued in the same cycle as each `rst_taken_o` pulse, but only if no earlier read is still waiting for `rd_valid_i`. No read is issued outside the held state.
- R6: While `dbg_paused_i`=1, the request is ignored: idle stays idle, and a drain in progress does not advance to the held state. A request still present in a cycle with `dbg_paused_i`=0 is accepted, even if that cycle is a single one.
- R7: If the request is sampled low in the held state and no read is outstanding, `core_held_o` falls in the next cycle. In that same cycle `restart_o` is 1, and it lasts exactly one cycle.
- R8: If the request drops while a dummy read is outstanding, `core_held_o` stays 1 and `restart_o` stays 0 until `rd_valid_i` is sampled. The cycle after that, `core_held_o` is 0 and `restart_o` pulses.
- R9: If the request is withdrawn while draining, the block returns to idle with no taken pulse and no restart pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, asynchronous, active low |
| rst_req_i | input | 1 | Local reset request, level |
| pipe_empty_i | input | 1 | Pipeline holds no unfinished instructions |
| dbg_paused_i | input | 1 | Core is paused under debugger control |
| rd_valid_i | input | 1 | Data for the outstanding dummy read has returned |
| drain_req_o | output | 1 | Ask the pipeline to finish its instructions |
| rst_taken_o | output | 1 | One-cycle pulse, on entry to reset and periodically while held |
| core_held_o | output | 1 | Core is held in local reset |
| restart_o | output | 1 | One-cycle pulse: restart fetching from the reset address |
| rd_req_o | output | 1 | One-cycle dummy read request |
| rd_addr_o | output | ADDR_W | Address of the dummy read (the reset address) |

## Verification
The hardest situation to reach is a request that drops while a dummy read is still outstanding, and above all while a periodic read has been skipped because an older one never returned. The bench enters the held state and answers the first read. It then leaves the read issued at the first periodic instant unanswered, so the next periodic instant shows a taken pulse with no read. Only after that does it withdraw the request and supply the late data, so that the delayed restart can be observed. The single-step case is reached by holding the request under a debug pause and lowering the pause for exactly one cycle.

// File: rtl/lrst_pkg.sv
package lrst_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRAIN = 2'd1,
      ST_HOLD  = 2'd2,
      ST_EXIT  = 2'd3
   } lrst_state_e;
endpackage

// File: rtl/lrst_tick.sv
// Interval counter for the held state: wrap_o marks the last cycle of each
// PERIOD-cycle window that starts at the entry cycle.
module lrst_tick #(
   parameter int PERIOD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic run_i,
   output logic wrap_o
);
   localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
   localparam bit IS_POW2 = ((PERIOD & (PERIOD - 1)) == 0);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (IS_POW2) begin : g_pow2
         // natural wrap of the counter
         assign cnt_nxt = cnt_q + 1'b1;
      end else begin : g_cmp
         assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   assign wrap_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= cnt_nxt;
      end
   end
endmodule

// File: rtl/lrst_rdgen.sv
// Dummy read issue with a single outstanding read; returned data is dropped.
module lrst_rdgen #(
   parameter int               ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic              rd_valid_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              busy_o
);
   logic req_q;
   logic pend_q;
   logic issue;

   assign issue = fire_i && !(req_q || pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         req_q <= issue;
         if (req_q) begin
            pend_q <= 1'b1;
         end else if (rd_valid_i) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign rd_req_o  = req_q;
   assign rd_addr_o = RESET_ADDR;
   // the cycle in which data returns already counts as free
   assign busy_o    = req_q || (pend_q && !rd_valid_i);
endmodule

// File: rtl/lrst_ctrl.sv
// State machine: idle -> drain -> hold -> (exit wait) -> idle.
module lrst_ctrl
   import lrst_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic empty_i,
   input  logic paused_i,
   input  logic wrap_i,
   input  logic busy_i,
   output logic drain_o,
   output logic held_o,
   output logic taken_o,
   output logic restart_o,
   output logic fire_o,
   output logic tick_clear_o,
   output logic tick_run_o
);
   lrst_state_e state_q, state_d;
   logic enter_hold;
   logic fire;
   logic leave;
   logic taken_q;
   logic restart_q;

   assign enter_hold = (state_q == ST_DRAIN) && req_i && empty_i && !paused_i;
   assign fire       = enter_hold || ((state_q == ST_HOLD) && req_i && wrap_i);
   assign leave      = ((state_q == ST_HOLD) && !req_i && !busy_i) ||
                       ((state_q == ST_EXIT) && !busy_i);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (req_i && !paused_i) state_d = ST_DRAIN;
         end
         ST_DRAIN: begin
            if (!req_i)          state_d = ST_IDLE;
            else if (enter_hold) state_d = ST_HOLD;
         end
         ST_HOLD: begin
            if (!req_i) state_d = busy_i ? ST_EXIT : ST_IDLE;
         end
         ST_EXIT: begin
            if (!busy_i) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         taken_q   <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         taken_q   <= fire;
         restart_q <= leave;
      end
   end

   assign drain_o      = (state_q == ST_DRAIN);
   assign held_o       = (state_q == ST_HOLD) || (state_q == ST_EXIT);
   assign taken_o      = taken_q;
   assign restart_o    = restart_q;
   assign fire_o       = fire;
   assign tick_clear_o = enter_hold;
   assign tick_run_o   = (state_q == ST_HOLD);
endmodule

// File: rtl/local_reset_seq.sv
module local_reset_seq #(
   parameter int               PERIOD     = 16,
   parameter int               ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_req_i,
   input  logic              pipe_empty_i,
   input  logic              dbg_paused_i,
   input  logic              rd_valid_i,
   output logic              drain_req_o,
   output logic              rst_taken_o,
   output logic              core_held_o,
   output logic              restart_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o
);
   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("local_reset_seq: PERIOD must be at least 2");
      end
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr
         $error("local_reset_seq: ADDR_W must lie in 2..64");
      end
   endgenerate

   logic wrap;
   logic busy;
   logic fire;
   logic tick_clear;
   logic tick_run;

   lrst_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (rst_req_i),
      .empty_i      (pipe_empty_i),
      .paused_i     (dbg_paused_i),
      .wrap_i       (wrap),
      .busy_i       (busy),
      .drain_o      (drain_req_o),
      .held_o       (core_held_o),
      .taken_o      (rst_taken_o),
      .restart_o    (restart_o),
      .fire_o       (fire),
      .tick_clear_o (tick_clear),
      .tick_run_o   (tick_run)
   );

   lrst_tick #(.PERIOD(PERIOD)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (tick_clear),
      .run_i   (tick_run),
      .wrap_o  (wrap)
   );

   lrst_rdgen #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_rdgen (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (fire),
      .rd_valid_i (rd_valid_i),
      .rd_req_o   (rd_req_o),
      .rd_addr_o  (rd_addr_o),
      .busy_o     (busy)
   );
endmodule

// File: rtl/local_reset_seq_chk.sv
module local_reset_seq_chk #(
   parameter int               PERIOD     = 16,
   parameter int               ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_1000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dbg_paused_i,
   input logic              drain_req_o,
   input logic              rst_taken_o,
   input logic              core_held_o,
   input logic              restart_o,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o
);
   // cycles since the last taken pulse while held (saturating)
   int unsigned gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                gap_q <= 0;
      else if (rst_taken_o)      gap_q <= 1;
      else if (!core_held_o)     gap_q <= 0;
      else if (gap_q < 32'hFFFF) gap_q <= gap_q + 1;
   end

   assert_drain_vs_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(drain_req_o && core_held_o));

   assert_taken_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_taken_o |=> !rst_taken_o);

   assert_taken_on_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_held_o) |-> rst_taken_o);

   assert_taken_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_taken_o && !$rose(core_held_o)) |-> (gap_q == PERIOD));

   assert_read_only_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (core_held_o && rd_addr_o == RESET_ADDR));

   assert_paused_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_paused_i && !drain_req_o && !core_held_o) |=> (!drain_req_o && !core_held_o));

   assert_restart_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |-> (!core_held_o && $past(core_held_o)));
endmodule

bind local_reset_seq local_reset_seq_chk #(
   .PERIOD(PERIOD), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dbg_paused_i (dbg_paused_i),
   .drain_req_o  (drain_req_o),
   .rst_taken_o  (rst_taken_o),
   .core_held_o  (core_held_o),
   .restart_o    (restart_o),
   .rd_req_o     (rd_req_o),
   .rd_addr_o    (rd_addr_o)
);

// File: tb/local_reset_seq_bench.sv
`timescale 1ns/1ps
module local_reset_seq_bench;
   localparam int PERIOD = 16;
   localparam logic [31:0] RADDR = 32'h0000_1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, empty = 1'b0, paused = 1'b0, valid = 1'b0;
   logic drain, taken, held, restart, rdreq;
   logic [31:0] rdaddr;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   local_reset_seq u_local_reset_seq (
      .clk(clk), .rst_n(rst_n), .rst_req_i(req), .pipe_empty_i(empty),
      .dbg_paused_i(paused), .rd_valid_i(valid),
      .drain_req_o(drain), .rst_taken_o(taken), .core_held_o(held),
      .restart_o(restart), .rd_req_o(rdreq), .rd_addr_o(rdaddr)
   );

   // {req,empty,paused,valid, drain,taken,rdreq,held,restart}
   localparam logic [8:0] TBL [9] = '{
      9'b0000_00000,  // idle
      9'b1000_10000,  // R2 drain requested
      9'b1000_10000,  // R2 still draining
      9'b1100_01110,  // R3 R5 entry: taken + read
      9'b1100_00010,  // R3 pulse over
      9'b1101_00010,  // R5 data returns, dropped
      9'b1100_00010,
      9'b0100_00001,  // R7 release, restart pulse
      9'b0000_00000   // R7 pulse over
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_out(input string tag, input logic [4:0] exp);
      chk(tag, {27'd0, drain, taken, rdreq, held, restart}, {27'd0, exp});
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      step();
      step();
      chk_out("R1 outputs in reset", 5'b00000);
      rst_n = 1'b1;
      step();
      chk_out("R1 idle after reset", 5'b00000);

      // table walk
      for (int i = 0; i < 9; i++) begin
         {req, empty, paused, valid} = TBL[i][8:5];
         step();
         chk_out($sformatf("table row %0d R2/R3/R5/R7", i), TBL[i][4:0]);
         if (i == 3) chk("R5 read address", rdaddr, RADDR);
      end

      // periodic pulses, skipped read when one is outstanding, delayed exit
      req = 1'b1; empty = 1'b1;
      step();
      chk_out("R2 drain before hold", 5'b10000);
      step();
      chk_out("R3 entry pulse", 5'b01110);
      for (int k = 1; k <= 2 * PERIOD; k++) begin
         valid = (k == 2);
         step();
         if (k == PERIOD)
            chk_out($sformatf("R4 R5 repeat pulse at %0d", k), 5'b01110);
         else if (k == 2 * PERIOD)
            chk_out("R5 taken without read while one is outstanding", 5'b01010);
         else
            chk_out($sformatf("R4 quiet cycle %0d", k), 5'b00010);
      end
      req = 1'b0;
      step();
      chk_out("R8 held while read outstanding", 5'b00010);
      step();
      chk_out("R8 still waiting", 5'b00010);
      valid = 1'b1;
      step();
      chk_out("R8 restart after data", 5'b00001);
      valid = 1'b0;
      step();
      chk_out("R8 restart single cycle", 5'b00000);

      // debug gating and single step
      req = 1'b1; paused = 1'b1; empty = 1'b0;
      for (int k = 0; k < 4; k++) begin
         step();
         chk_out("R6 request ignored while paused", 5'b00000);
      end
      paused = 1'b0;
      step();
      chk_out("R6 accepted in one-cycle release", 5'b10000);
      paused = 1'b1; empty = 1'b1;
      step();
      step();
      chk_out("R6 drain frozen while paused", 5'b10000);
      paused = 1'b0;
      step();
      chk_out("R6 hold after release", 5'b01110);
      req = 1'b0;
      step();
      chk_out("R8 exit wait on fresh read", 5'b00010);
      valid = 1'b1;
      step();
      chk_out("R8 restart after fresh read data", 5'b00001);
      valid = 1'b0;

      // withdrawal during drain
      req = 1'b1; empty = 1'b0;
      step();
      chk_out("R9 draining", 5'b10000);
      req = 1'b0;
      step();
      chk_out("R9 withdrawn, no taken or restart", 5'b00000);
      step();
      chk_out("R9 stays idle", 5'b00000);

      // global reset in the middle of the hold
      req = 1'b1; empty = 1'b1;
      step();
      step();
      chk("R1 held before global reset", {31'd0, held}, 32'd1);
      rst_n = 1'b0;
      #1;
      chk_out("R1 immediate clear without edge", 5'b00000);
      step();
      req = 1'b0;
      rst_n = 1'b1;
      step();
      chk_out("R1 idle after release", 5'b00000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule